// File: doc/BRIEF.md
# SPI Flash Command Register Engine

This block lets a host run one short serial-flash command at a time through a byte-wide register bus. The host loads an opcode byte, up to three outgoing bytes and a packed control byte. The control byte holds a start bit, a count of bytes to send after the opcode, a count of bytes to receive, and a three-bit command class. When the start bit is written as 1, the engine drives a single-chip-select SPI master in mode 0. It clears the start bit once the whole transaction has finished. The host polls the control register until the bit reads 0 and then reads the received bytes.

The command class selects extra frames that the engine adds by itself. Status-write and erase classes are preceded by a separate write-enable frame. The erase class is followed by status-register polling frames, which repeat until the flash reports that its internal operation is over. Because an erase can take any amount of time, completion never times out. The SPI clock is derived from the system clock by a divider parameter. Chip select always stays high for a minimum gap between frames.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset every register reads 0, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: A write to offset 0x60 with bit 0 set while idle latches bits [7:1] as the command and launches it. Bit 0 then reads 1. The byte held at offset 0x61 is the first byte of the main frame, shifted out MSB first.
- R3: Control bits [4:3] give the number of bytes (0 to 3) sent after the opcode. These bytes are taken from offsets 0x64, 0x65 and 0x66, in that order.
- R4: Control bits [2:1] give the number of bytes (0 to 3) received after the sent bytes, while the engine shifts out 0x00. They are stored at offsets 0x67, 0x68 and 0x69 in order of arrival. Receive registers beyond the count keep their previous values.
- R5: The SPI is mode 0. `spi_sclk` is 0 whenever `spi_cs_n` is 1, `spi_mosi` changes only while `spi_sclk` is 0, and `spi_miso` is sampled on the rising edge.
- R6: Classes 3'b011 (status write) and 3'b101 (erase) in bits [7:5] are preceded by a one-byte frame carrying 0x06.
- R7: Class 3'b101 is followed by two-byte frames (0x05, then 0x00). These repeat while bit 0 of the received status byte is 1 and stop after the first frame that returns bit 0 as 0. Other status bits are ignored, and there is no time limit.
- R8: Every other class, including 3'b010, produces the main frame only.
- R9: Bit 0 of offset 0x60 stays 1 until the last frame has ended and its chip-select gap has elapsed. While it is 1, host writes to offsets 0x60 to 0x69 have no effect, and reads of 0x60 return the latched fields with bit 0 set.
- R10: Chip select stays high for at least 4*CLK_DIV system clocks between any two frames, including frames of consecutive commands.
- R11: Each SPI clock high phase lasts exactly CLK_DIV system clocks.
- R12: Read data is registered: `bus_rdata` updates on the clock edge where `bus_re` is 1. Unmapped offsets read 0, and host writes to offsets 0x67 to 0x69 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Two things can fall in the same cycle: the hardware clearing the start bit at the end of the final gap, and a host access to the control register. The bench polls the control register every other cycle, so one poll meets that clearing edge. The read must show either the full busy value or the done value with its fields intact, never a mixture. The bench then launches the next command at once, so a new launch closely follows a completion. The chip-select gap measured across that boundary must still meet the minimum. Writes issued in the first cycles of a long erase must leave the frames and the register readback unchanged.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam logic [7:0] OFS_CTRL = 8'h60;
  localparam logic [7:0] OFS_OPC  = 8'h61;
  localparam logic [7:0] OFS_TX0  = 8'h64;
  localparam logic [7:0] OFS_RX0  = 8'h67;
  localparam int         NSLOT    = 3;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;

  localparam logic [2:0] CLS_WRSR  = 3'b011;
  localparam logic [2:0] CLS_ERASE = 3'b101;

  typedef struct packed {
    logic [2:0] cls;
    logic [1:0] wr_n;
    logic [1:0] rd_n;
  } cmd_ctrl_t;

  typedef enum logic [1:0] {PH_WREN, PH_MAIN, PH_POLL} frame_ph_t;
  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP} seq_st_t;

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_go,
  input  logic [7:0] tx_byte,
  input  logic       spi_miso,
  output logic       spi_sclk,
  output logic       spi_mosi,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic             act_q, act_d;
  logic             sclk_q, sclk_d;
  logic             done_q, done_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic [7:0]       rx_q, rx_d;
  logic             tick;

  always_comb begin
    act_d  = act_q;
    sclk_d = sclk_q;
    done_d = 1'b0;
    div_d  = div_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    tick   = act_q && (div_q == DIV_LAST);
    if (byte_go && !act_q) begin
      act_d  = 1'b1;
      sh_d   = tx_byte;
      bit_d  = 3'd0;
      div_d  = '0;
      sclk_d = 1'b0;
    end else if (act_q) begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (!sclk_q) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[6:0], spi_miso};
        end else begin
          sclk_d = 1'b0;
          sh_d   = {sh_q[6:0], 1'b0};
          bit_d  = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            act_d  = 1'b0;
            done_d = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= 3'd0;
      sh_q   <= 8'h00;
      rx_q   <= 8'h00;
    end else begin
      act_q  <= act_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
    end
  end

  assign spi_sclk  = sclk_q;
  assign spi_mosi  = sh_q[7];
  assign byte_done = done_q;
  assign rx_byte   = rx_q;
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [7:0]           bus_wdata,
  input  logic                 bus_we,
  input  logic                 bus_re,
  output logic [7:0]           bus_rdata,
  input  logic                 busy,
  input  logic                 rx_we,
  input  logic [1:0]           rx_sel,
  input  logic [7:0]           rx_data,
  output logic                 launch,
  output cmd_ctrl_t            launch_ctrl,
  output cmd_ctrl_t            ctrl,
  output logic [7:0]           opcode,
  output logic [NSLOT-1:0][7:0] tx_bytes
);
  cmd_ctrl_t             ctrl_q, ctrl_d;
  logic [7:0]            opc_q, opc_d;
  logic [NSLOT-1:0][7:0] tx_q;
  logic [NSLOT-1:0][7:0] rx_q;
  logic [7:0]            rdata_q, rdata_d;
  logic                  wr_ok, hit_ctrl, hit_opc;

  assign wr_ok    = bus_we && !busy;
  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_opc  = (bus_addr == ADDR_W'(OFS_OPC));

  assign launch      = wr_ok && hit_ctrl && bus_wdata[0];
  assign launch_ctrl = cmd_ctrl_t'(bus_wdata[7:1]);

  always_comb begin
    ctrl_d = ctrl_q;
    opc_d  = opc_q;
    if (wr_ok && hit_ctrl) ctrl_d = cmd_ctrl_t'(bus_wdata[7:1]);
    if (wr_ok && hit_opc)  opc_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      opc_q  <= 8'h00;
    end else begin
      ctrl_q <= ctrl_d;
      opc_q  <= opc_d;
    end
  end

  for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
    logic tx_en, rx_en;
    assign tx_en = wr_ok && (bus_addr == ADDR_W'(OFS_TX0 + 8'(gi)));
    assign rx_en = rx_we && (rx_sel == 2'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_q[gi] <= 8'h00;
        rx_q[gi] <= 8'h00;
      end else begin
        if (tx_en) tx_q[gi] <= bus_wdata;
        if (rx_en) rx_q[gi] <= rx_data;
      end
    end
  end

  always_comb begin
    rdata_d = 8'h00;
    if (hit_ctrl) rdata_d = {ctrl_q, busy};
    if (hit_opc)  rdata_d = opc_q;
    for (int i = 0; i < NSLOT; i++) begin
      if (bus_addr == ADDR_W'(OFS_TX0 + 8'(i))) rdata_d = tx_q[i];
      if (bus_addr == ADDR_W'(OFS_RX0 + 8'(i))) rdata_d = rx_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= 8'h00;
    else if (bus_re) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign ctrl      = ctrl_q;
  assign opcode    = opc_q;
  assign tx_bytes  = tx_q;
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  launch,
  input  cmd_ctrl_t             launch_ctrl,
  input  cmd_ctrl_t             ctrl,
  input  logic [7:0]            opcode,
  input  logic [NSLOT-1:0][7:0] tx_bytes,
  input  logic                  byte_done,
  input  logic [7:0]            rx_byte,
  output logic                  byte_go,
  output logic [7:0]            byte_out,
  output logic                  cs_n,
  output logic                  busy,
  output logic                  rx_we,
  output logic [1:0]            rx_sel,
  output logic [7:0]            rx_data
);
  localparam int GAP_CYC = 4 * CLK_DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

  seq_st_t   st_q, st_d;
  frame_ph_t ph_q, ph_d, nph_q, nph_d;
  logic [2:0]    idx_q, idx_d;
  logic [GW-1:0] gcnt_q, gcnt_d;
  logic cs_q, cs_d, busy_q, busy_d, go_q, go_d, fin_q, fin_d;
  logic [2:0] last_idx, rx_pos;
  logic       need_wren, is_erase;

  assign need_wren = (launch_ctrl.cls == CLS_WRSR) || (launch_ctrl.cls == CLS_ERASE);
  assign is_erase  = (ctrl.cls == CLS_ERASE);
  assign rx_pos    = idx_q - 3'd1 - {1'b0, ctrl.wr_n};

  always_comb begin
    case (ph_q)
      PH_WREN: last_idx = 3'd0;
      PH_POLL: last_idx = 3'd1;
      default: last_idx = {1'b0, ctrl.wr_n} + {1'b0, ctrl.rd_n};
    endcase
  end

  always_comb begin
    byte_out = 8'h00;
    case (ph_q)
      PH_WREN: byte_out = OP_WREN;
      PH_POLL: byte_out = (idx_q == 3'd0) ? OP_RDSR : 8'h00;
      default: begin
        if (idx_q == 3'd0)                     byte_out = opcode;
        else if (idx_q <= {1'b0, ctrl.wr_n})   byte_out = tx_bytes[idx_q[1:0] - 2'd1];
      end
    endcase
  end

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    nph_d  = nph_q;
    idx_d  = idx_q;
    gcnt_d = gcnt_q;
    cs_d   = cs_q;
    busy_d = busy_q;
    fin_d  = fin_q;
    go_d   = 1'b0;
    rx_we  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (launch) begin
          busy_d = 1'b1;
          st_d   = ST_FRAME;
          ph_d   = need_wren ? PH_WREN : PH_MAIN;
          idx_d  = 3'd0;
          cs_d   = 1'b0;
          go_d   = 1'b1;
        end
      end
      ST_FRAME: begin
        if (byte_done) begin
          rx_we = (ph_q == PH_MAIN) && (idx_q > {1'b0, ctrl.wr_n});
          if (idx_q == last_idx) begin
            st_d   = ST_GAP;
            cs_d   = 1'b1;
            gcnt_d = '0;
            case (ph_q)
              PH_WREN: begin fin_d = 1'b0; nph_d = PH_MAIN; end
              PH_POLL: begin fin_d = !rx_byte[0]; nph_d = PH_POLL; end
              default: begin fin_d = !is_erase; nph_d = PH_POLL; end
            endcase
          end else begin
            idx_d = idx_q + 3'd1;
            go_d  = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (gcnt_q == GAP_LAST) begin
          if (fin_q) begin
            busy_d = 1'b0;
            st_d   = ST_IDLE;
          end else begin
            st_d  = ST_FRAME;
            ph_d  = nph_q;
            idx_d = 3'd0;
            cs_d  = 1'b0;
            go_d  = 1'b1;
          end
        end else begin
          gcnt_d = gcnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_MAIN;
      nph_q  <= PH_MAIN;
      idx_q  <= 3'd0;
      gcnt_q <= '0;
      cs_q   <= 1'b1;
      busy_q <= 1'b0;
      go_q   <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      nph_q  <= nph_d;
      idx_q  <= idx_d;
      gcnt_q <= gcnt_d;
      cs_q   <= cs_d;
      busy_q <= busy_d;
      go_q   <= go_d;
      fin_q  <= fin_d;
    end
  end

  assign byte_go = go_q;
  assign cs_n    = cs_q;
  assign busy    = busy_q;
  assign rx_sel  = rx_pos[1:0];
  assign rx_data = rx_byte;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  cmd_ctrl_t             ctrl_w, launch_ctrl_w;
  logic [7:0]            opcode_w, byte_out_w, rx_byte_w, rx_data_w;
  logic [NSLOT-1:0][7:0] tx_w;
  logic                  launch_w, seq_busy, rx_we_w, byte_go_w, byte_done_w;
  logic [1:0]            rx_sel_w;

  spi_cmd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .busy(seq_busy),
    .rx_we(rx_we_w), .rx_sel(rx_sel_w), .rx_data(rx_data_w),
    .launch(launch_w), .launch_ctrl(launch_ctrl_w), .ctrl(ctrl_w),
    .opcode(opcode_w), .tx_bytes(tx_w)
  );

  spi_cmd_seq #(.CLK_DIV(CLK_DIV)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .launch(launch_w), .launch_ctrl(launch_ctrl_w), .ctrl(ctrl_w),
    .opcode(opcode_w), .tx_bytes(tx_w),
    .byte_done(byte_done_w), .rx_byte(rx_byte_w),
    .byte_go(byte_go_w), .byte_out(byte_out_w),
    .cs_n(spi_cs_n), .busy(seq_busy),
    .rx_we(rx_we_w), .rx_sel(rx_sel_w), .rx_data(rx_data_w)
  );

  spi_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_sync_n),
    .byte_go(byte_go_w), .tx_byte(byte_out_w), .spi_miso(spi_miso),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .byte_done(byte_done_w), .rx_byte(rx_byte_w)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int CLK_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic busy
);
  logic [15:0] hi_cnt_q;
  logic [15:0] cs_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q <= 16'd0;
      cs_hi_q  <= 16'hFFFF;
    end else begin
      hi_cnt_q <= spi_sclk ? hi_cnt_q + 16'd1 : 16'd0;
      if (!spi_cs_n)               cs_hi_q <= 16'd0;
      else if (cs_hi_q != 16'hFFFF) cs_hi_q <= cs_hi_q + 16'd1;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R5
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R5
  AST_CS_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (cs_hi_q >= 16'(4 * CLK_DIV))); // R10
  AST_SCLK_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sclk) |-> (hi_cnt_q == 16'(CLK_DIV))); // R11
  AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy); // R9
  AST_DONE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(spi_cs_n)); // R9
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi), .busy(seq_busy)
);

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;
  localparam int CLK_DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic       spi_sclk, spi_cs_n, spi_mosi;
  logic       spi_miso = 1'b0;

  always #2 clk = ~clk;

  spi_cmd_engine #(.CLK_DIV(CLK_DIV), .ADDR_W(8)) i_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] data_resp(input logic [7:0] op, input int k);
    return op ^ 8'(k * 59) ^ 8'hA5;
  endfunction

  // flash model
  logic [7:0] fr_bytes [16][8];
  int         fr_len   [16];
  int         fr_cnt = 0;
  int         bit_n = 0;
  logic [7:0] sh_in = 8'h00;
  logic [7:0] cur_op = 8'h00;
  int         poll_left = 0;

  function automatic logic [7:0] model_resp(input int k);
    if (k == 0) return 8'h00;
    if (cur_op == 8'h05) return (k == 1) ? ((poll_left > 0) ? 8'h03 : 8'h02) : 8'h00;
    return data_resp(cur_op, k);
  endfunction

  always @(negedge spi_cs_n) begin
    bit_n = 0;
    spi_miso = 1'b0;
  end

  always @(posedge spi_cs_n) begin
    if (fr_cnt < 16) fr_len[fr_cnt] = bit_n / 8;
    fr_cnt++;
    if (cur_op == 8'h05 && poll_left > 0) poll_left--;
  end

  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      sh_in = {sh_in[6:0], spi_mosi};
      bit_n++;
      if (bit_n % 8 == 0) begin
        if (fr_cnt < 16 && bit_n / 8 <= 8) fr_bytes[fr_cnt][bit_n/8-1] = sh_in;
        if (bit_n == 8) cur_op = sh_in;
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (!spi_cs_n) begin
      logic [7:0] rb;
      rb = model_resp(bit_n / 8);
      spi_miso = rb[7 - (bit_n % 8)];
    end
  end

  // timing monitors
  int cs_hi = 1000000, min_gap = 1000000, sc_hi = 0, min_hi = 1000000, max_hi = 0;
  logic prev_cs = 1'b1, prev_sc = 1'b0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (!spi_cs_n && prev_cs && cs_hi < min_gap) min_gap = cs_hi;
      if (!spi_sclk && prev_sc) begin
        if (sc_hi < min_hi) min_hi = sc_hi;
        if (sc_hi > max_hi) max_hi = sc_hi;
      end
      cs_hi = spi_cs_n ? cs_hi + 1 : 0;
      sc_hi = spi_sclk ? sc_hi + 1 : 0;
      prev_cs = spi_cs_n;
      prev_sc = spi_sclk;
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  logic [7:0] exp_rx [3];

  task automatic wait_done(output logic [7:0] c);
    int guard = 0;
    c = 8'h01;
    while (c[0] && guard < 4000) begin
      bus_rd(8'h60, c);
      guard++;
    end
    chk(!c[0], "R7 completion", int'(c), 0);
  endtask

  task automatic run_cmd(input logic [2:0] cls, input int wr, input int rd, input logic [7:0] op);
    logic [7:0] c, v, tx [3];
    bit wren, ers;
    int npoll, f;
    wren = (cls == 3'b011) || (cls == 3'b101);
    ers  = (cls == 3'b101);
    npoll = ers ? (wr + rd) % 3 : 0;
    for (int i = 0; i < 3; i++) begin
      tx[i] = op ^ 8'(8'h11 * (i + 1));
      bus_wr(8'h64 + 8'(i), tx[i]);
    end
    bus_wr(8'h61, op);
    poll_left = npoll;
    fr_cnt = 0;
    bus_wr(8'h60, {cls, 2'(wr), 2'(rd), 1'b1});
    bus_rd(8'h60, c);
    chk(c == {cls, 2'(wr), 2'(rd), 1'b1}, "R2 start reads 1", int'(c), int'({cls, 2'(wr), 2'(rd), 1'b1}));
    wait_done(c);
    chk(c == {cls, 2'(wr), 2'(rd), 1'b0}, "R9 fields after done", int'(c), int'({cls, 2'(wr), 2'(rd), 1'b0}));
    chk(fr_cnt == (wren ? 1 : 0) + 1 + (ers ? npoll + 1 : 0), "R8 frame count", fr_cnt,
        (wren ? 1 : 0) + 1 + (ers ? npoll + 1 : 0));
    f = 0;
    if (wren) begin
      chk(fr_len[0] == 1 && fr_bytes[0][0] == 8'h06, "R6 write-enable frame", int'(fr_bytes[0][0]), 6);
      f = 1;
    end
    chk(fr_len[f] == 1 + wr + rd, "R4 main frame length", fr_len[f], 1 + wr + rd);
    chk(fr_bytes[f][0] == op, "R2 opcode first", int'(fr_bytes[f][0]), int'(op));
    for (int i = 0; i < wr; i++)
      chk(fr_bytes[f][1+i] == tx[i], "R3 sent byte order", int'(fr_bytes[f][1+i]), int'(tx[i]));
    for (int i = 0; i < rd; i++)
      chk(fr_bytes[f][1+wr+i] == 8'h00, "R4 filler while reading", int'(fr_bytes[f][1+wr+i]), 0);
    if (ers) begin
      for (int p = 0; p <= npoll; p++)
        chk(fr_len[f+1+p] == 2 && fr_bytes[f+1+p][0] == 8'h05 && fr_bytes[f+1+p][1] == 8'h00,
            "R7 status poll frame", int'(fr_bytes[f+1+p][0]), 5);
    end
    for (int j = 0; j < 3; j++) begin
      if (j < rd) exp_rx[j] = data_resp(op, 1 + wr + j);
      bus_rd(8'h67 + 8'(j), v);
      chk(v == exp_rx[j], "R4 received bytes", int'(v), int'(exp_rx[j]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, c;
    logic [2:0] cls_list [5];
    int n;
    cls_list[0] = 3'b010; cls_list[1] = 3'b011; cls_list[2] = 3'b101;
    cls_list[3] = 3'b000; cls_list[4] = 3'b111;
    for (int j = 0; j < 3; j++) exp_rx[j] = 8'h00;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 pins in reset", {spi_cs_n, spi_sclk}, 2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: register reset values
    for (int a = 8'h60; a <= 8'h69; a++) begin
      bus_rd(8'(a), v);
      chk(v == 8'h00, "R1 register reset", int'(v), 0);
    end
    // R12: unmapped and read-only receive slots
    bus_rd(8'h62, v); chk(v == 8'h00, "R12 unmapped", int'(v), 0);
    bus_rd(8'h6A, v); chk(v == 8'h00, "R12 unmapped", int'(v), 0);
    bus_wr(8'h67, 8'h5A);
    bus_rd(8'h67, v); chk(v == 8'h00, "R12 rx not host-writable", int'(v), 0);
    // sweep
    n = 0;
    for (int k = 0; k < 5; k++)
      for (int wr = 0; wr < 4; wr++)
        for (int rd = 0; rd < 4; rd++) begin
          run_cmd(cls_list[k], wr, rd, 8'h40 + 8'(n));
          n++;
        end
    // R9: writes during a long erase are ignored
    for (int i = 0; i < 3; i++) bus_wr(8'h64 + 8'(i), 8'hC0 + 8'(i));
    bus_wr(8'h61, 8'h7A);
    poll_left = 3;
    fr_cnt = 0;
    bus_wr(8'h60, {3'b101, 2'd3, 2'd0, 1'b1});
    bus_wr(8'h60, 8'h00);
    bus_wr(8'h61, 8'h99);
    bus_wr(8'h64, 8'hEE);
    bus_wr(8'h60, {3'b010, 2'd1, 2'd1, 1'b1});
    bus_rd(8'h60, c);
    chk(c == {3'b101, 2'd3, 2'd0, 1'b1}, "R9 live control while busy", int'(c), int'({3'b101, 2'd3, 2'd0, 1'b1}));
    wait_done(c);
    chk(fr_cnt == 1 + 1 + 4, "R9 frames unaffected by writes", fr_cnt, 6);
    chk(fr_bytes[1][0] == 8'h7A, "R9 opcode kept", int'(fr_bytes[1][0]), 8'h7A);
    chk(fr_bytes[1][1] == 8'hC0, "R9 tx kept", int'(fr_bytes[1][1]), 8'hC0);
    bus_rd(8'h61, v); chk(v == 8'h7A, "R9 opcode reg kept", int'(v), 8'h7A);
    bus_rd(8'h64, v); chk(v == 8'hC0, "R9 tx reg kept", int'(v), 8'hC0);
    // R5 idle levels, R10 gap, R11 high phase
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R5 idle levels", {spi_cs_n, spi_sclk}, 2);
    chk(min_gap >= 4 * CLK_DIV, "R10 minimum cs gap", min_gap, 4 * CLK_DIV);
    chk(min_hi == CLK_DIV && max_hi == CLK_DIV, "R11 sclk high length", max_hi, CLK_DIV);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule